// File: doc/BRIEF.md
# Link request issue controller

This block sits on the link side of a serial-bus node and decides whether a request from the link core may be sent to the PHY over the single-wire request line. The link core raises one strobe per request kind. The block checks that strobe against the kind's admission rule, which depends on:

- the decoded CTL bus state and which side owns CTL;
- whether an arbitration request is still outstanding;
- whether a register read still waits for its status transfer;
- the timing window that follows a received packet;
- the isochronous-period events.

An admitted request is serialised onto `lreq_o` at one bit per clock. A refused one is dropped, and a reject pulse reports the refusal.

Outstanding state is tracked inside the block. A grant, an explicit cancel or a bus reset ends an arbitration request. A subaction gap also ends it, but only for immediate and isochronous requests. A status-complete indication ends a pending register read. Only one serial frame is in flight at a time.

Top module: `lreq_issue_ctrl`

## Requirements
- R1: The line `lreq_o` is 0 whenever no frame is in flight. An admitted request is sent MSB first, one bit per clock, starting in the cycle after the strobe edge. The frame is a start bit 1, then the 3-bit kind code, then the payload (default 4 bits, MSB first), then a stop bit 0. The kind codes are: 0 immediate, 1 isochronous, 2 priority, 3 fair, 4 register read, 5 register write, 6 acceleration control. `busy_o` is high for exactly the frame length.
- R2: A strobe sampled while a frame is in flight is rejected.
- R3: `req_stb_i` bit k strobes kind code k. The result shows as a one-cycle `accept_o` or `reject_o` pulse in the cycle after the strobe edge, never both. A rejected strobe starts no frame. A strobe with more than one bit set is rejected.
- R4: Immediate, isochronous, priority and fair are arbitration requests. While one of them is outstanding, any new one is rejected. An outstanding arbitration request ends on `grant_i` or `cancel_i`.
- R5: `subact_gap_i` ends an outstanding immediate or isochronous request. It does not end an outstanding priority or fair request.
- R6: `bus_reset_i` ends any outstanding arbitration request. An arbitration strobe sampled together with `bus_reset_i` is rejected.
- R7: A register-read request stays pending from its admission until `rd_stat_done_i`. While it is pending, both register-read and register-write strobes are rejected.
- R8: Fair and priority requests are admitted only when the PHY owns CTL (`link_owns_ctl_i`=0) and CTL shows Idle (00) or Status (01).
- R9: An immediate request is admitted only when the PHY owns CTL and CTL shows Receive (10) or Idle (00). It must also be strobed 1 to 4 cycles after the `pkt_end_i` edge. The same cycle as that edge, or 5 or more cycles later, is rejected.
- R10: Isochronous, register-read and register-write requests are admitted in any CTL state and under either owner. An isochronous strobe flagged `iso_hold_i` (append to the packet now being sent) is rejected.
- R11: An acceleration-control request carries the new accelerate value in payload bit 0.
  - Value 0 is admitted only with `iso_start_i`=1, `accel_en_i`=1 and `cycle_master_i`=0.
  - Value 1 is admitted only with `iso_end_i`=1 and `cycle_master_i`=0.
  - Both are independent of CTL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_stb_i | input | 7 | Per-kind request strobes, bit k = kind code k |
| req_payload_i | input | PAYLOAD_W | Payload bits of the frame; bit 0 is the accelerate value for kind 6 |
| iso_hold_i | input | 1 | Isochronous strobe asks to append to the current packet |
| ctl_state_i | input | 2 | Decoded CTL state: 00 Idle, 01 Status, 10 Receive, 11 Grant/Transmit |
| link_owns_ctl_i | input | 1 | Link currently drives CTL |
| pkt_end_i | input | 1 | Received packet has just ended |
| iso_start_i | input | 1 | Isochronous period starts |
| iso_end_i | input | 1 | Isochronous period ends |
| accel_en_i | input | 1 | Acceleration enable bit |
| cycle_master_i | input | 1 | Node is the cycle master |
| grant_i | input | 1 | Grant for the outstanding arbitration request |
| cancel_i | input | 1 | Link cancels its outstanding arbitration request |
| subact_gap_i | input | 1 | Subaction gap detected |
| bus_reset_i | input | 1 | Bus reset detected |
| rd_stat_done_i | input | 1 | Status transfer for the register read has finished |
| lreq_o | output | 1 | Serial request line |
| busy_o | output | 1 | Frame in flight |
| accept_o | output | 1 | Strobe admitted (one-cycle pulse) |
| reject_o | output | 1 | Strobe refused (one-cycle pulse) |

## Verification
The accept or reject verdict appears one cycle after the edge that samples the strobe, and the start bit appears in that same cycle. Frame bit i is due i cycles after the start bit, and `busy_o` falls after frame-length cycles. The bench drives each strobe for exactly one edge and reads the verdict at the following falling edge. It then steps one falling edge per frame bit. For every directed case it counts edges explicitly from the `pkt_end_i` pulse or from the clearing event to the strobe edge. This is how it places strobes at the fourth and fifth cycles of the immediate window and right after a grant, cancel, gap or bus reset.

// File: rtl/lreq_pkg.sv
package lreq_pkg;
  localparam int unsigned NUM_KINDS = 7;
  localparam int unsigned KIND_W    = 3;

  typedef enum logic [1:0] {
    CTL_IDLE    = 2'b00,
    CTL_STATUS  = 2'b01,
    CTL_RECEIVE = 2'b10,
    CTL_XMIT    = 2'b11
  } ctl_e;

  typedef enum logic [KIND_W-1:0] {
    K_IMM   = 3'd0,
    K_ISO   = 3'd1,
    K_PRI   = 3'd2,
    K_FAIR  = 3'd3,
    K_RDREG = 3'd4,
    K_WRREG = 3'd5,
    K_ACCEL = 3'd6
  } kind_e;

  function automatic logic is_arb(kind_e k);
    return (k == K_IMM) || (k == K_ISO) || (k == K_PRI) || (k == K_FAIR);
  endfunction
endpackage

// File: rtl/lreq_admit.sv
module lreq_admit
  import lreq_pkg::*;
(
  input  logic [NUM_KINDS-1:0] stb_i,
  input  logic                 accel_val_i,
  input  logic [1:0]           ctl_i,
  input  logic                 link_owns_i,
  input  logic                 win_open_i,
  input  logic                 iso_hold_i,
  input  logic                 iso_start_i,
  input  logic                 iso_end_i,
  input  logic                 accel_en_i,
  input  logic                 cycle_master_i,
  input  logic                 busy_i,
  input  logic                 bus_pend_i,
  input  logic                 rd_pend_i,
  input  logic                 bus_reset_i,
  output logic                 accept_o,
  output logic                 reject_o,
  output kind_e                kind_o
);
  logic any_stb, single_stb, kind_ok, arb_block, reg_block;
  ctl_e ctl;

  assign ctl        = ctl_e'(ctl_i);
  assign any_stb    = |stb_i;
  assign single_stb = any_stb && ((stb_i & (stb_i - 1'b1)) == '0);

  always_comb begin
    kind_o = K_IMM;
    for (int k = 0; k < NUM_KINDS; k++)
      if (stb_i[k]) kind_o = kind_e'(k[KIND_W-1:0]);
  end

  always_comb begin
    kind_ok = 1'b0;
    unique case (kind_o)
      K_FAIR, K_PRI: kind_ok = !link_owns_i && (ctl == CTL_IDLE || ctl == CTL_STATUS);
      K_IMM:         kind_ok = !link_owns_i && (ctl == CTL_IDLE || ctl == CTL_RECEIVE)
                               && win_open_i;
      K_ISO:         kind_ok = !iso_hold_i;
      K_RDREG,
      K_WRREG:       kind_ok = 1'b1;
      K_ACCEL:       kind_ok = !cycle_master_i &&
                               (accel_val_i ? iso_end_i : (iso_start_i && accel_en_i));
      default:       kind_ok = 1'b0;
    endcase
  end

  assign arb_block = is_arb(kind_o) && (bus_pend_i || bus_reset_i);
  assign reg_block = (kind_o == K_RDREG || kind_o == K_WRREG) && rd_pend_i;

  assign accept_o = single_stb && !busy_i && kind_ok && !arb_block && !reg_block;
  assign reject_o = any_stb && !accept_o;
endmodule

// File: rtl/lreq_pend.sv
module lreq_pend
  import lreq_pkg::*;
#(
  parameter int unsigned IMM_WIN = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  accept_i,
  input  kind_e kind_i,
  input  logic  grant_i,
  input  logic  cancel_i,
  input  logic  subact_gap_i,
  input  logic  bus_reset_i,
  input  logic  rd_stat_done_i,
  input  logic  pkt_end_i,
  output logic  bus_pend_o,
  output logic  rd_pend_o,
  output logic  win_open_o
);
  localparam int unsigned WIN_W = $clog2(IMM_WIN + 1);

  logic             bus_pend_q, gap_cancel_q, rd_pend_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_pend_q   <= 1'b0;
      gap_cancel_q <= 1'b0;
    end else if (bus_reset_i) begin
      bus_pend_q   <= 1'b0;
    end else if (accept_i && is_arb(kind_i)) begin
      bus_pend_q   <= 1'b1;
      gap_cancel_q <= (kind_i == K_IMM) || (kind_i == K_ISO);
    end else if (grant_i || cancel_i || (subact_gap_i && gap_cancel_q)) begin
      bus_pend_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           rd_pend_q <= 1'b0;
    else if (accept_i && kind_i == K_RDREG) rd_pend_q <= 1'b1;
    else if (rd_stat_done_i)               rd_pend_q <= 1'b0;
  end

  // countdown of the cycles left to start an immediate request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          win_q <= '0;
    else if (pkt_end_i)   win_q <= WIN_W'(IMM_WIN);
    else if (win_q != '0) win_q <= win_q - 1'b1;
  end

  assign bus_pend_o = bus_pend_q;
  assign rd_pend_o  = rd_pend_q;
  assign win_open_o = (win_q != '0);
endmodule

// File: rtl/lreq_ser.sv
module lreq_ser
  import lreq_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  kind_e                kind_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic                 lreq_o,
  output logic                 busy_o
);
  localparam int unsigned FRAME_W = PAYLOAD_W + KIND_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= {1'b1, kind_i, payload_i, 1'b0};
      cnt_q <= CNT_W'(FRAME_W);
    end else if (cnt_q != '0) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign lreq_o = sh_q[FRAME_W-1];
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/lreq_issue_ctrl.sv
module lreq_issue_ctrl
  import lreq_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 4,
  parameter int unsigned IMM_WIN   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [6:0]           req_stb_i,
  input  logic [PAYLOAD_W-1:0] req_payload_i,
  input  logic                 iso_hold_i,
  input  logic [1:0]           ctl_state_i,
  input  logic                 link_owns_ctl_i,
  input  logic                 pkt_end_i,
  input  logic                 iso_start_i,
  input  logic                 iso_end_i,
  input  logic                 accel_en_i,
  input  logic                 cycle_master_i,
  input  logic                 grant_i,
  input  logic                 cancel_i,
  input  logic                 subact_gap_i,
  input  logic                 bus_reset_i,
  input  logic                 rd_stat_done_i,
  output logic                 lreq_o,
  output logic                 busy_o,
  output logic                 accept_o,
  output logic                 reject_o
);
  logic  acc_now, rej_now, bus_pend, rd_pend, win_open, busy;
  kind_e kind;
  logic  accept_q, reject_q;

  lreq_admit i_admit (
    .stb_i          (req_stb_i),
    .accel_val_i    (req_payload_i[0]),
    .ctl_i          (ctl_state_i),
    .link_owns_i    (link_owns_ctl_i),
    .win_open_i     (win_open),
    .iso_hold_i     (iso_hold_i),
    .iso_start_i    (iso_start_i),
    .iso_end_i      (iso_end_i),
    .accel_en_i     (accel_en_i),
    .cycle_master_i (cycle_master_i),
    .busy_i         (busy),
    .bus_pend_i     (bus_pend),
    .rd_pend_i      (rd_pend),
    .bus_reset_i    (bus_reset_i),
    .accept_o       (acc_now),
    .reject_o       (rej_now),
    .kind_o         (kind)
  );

  lreq_pend #(.IMM_WIN(IMM_WIN)) i_pend (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .accept_i       (acc_now),
    .kind_i         (kind),
    .grant_i        (grant_i),
    .cancel_i       (cancel_i),
    .subact_gap_i   (subact_gap_i),
    .bus_reset_i    (bus_reset_i),
    .rd_stat_done_i (rd_stat_done_i),
    .pkt_end_i      (pkt_end_i),
    .bus_pend_o     (bus_pend),
    .rd_pend_o      (rd_pend),
    .win_open_o     (win_open)
  );

  lreq_ser #(.PAYLOAD_W(PAYLOAD_W)) i_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (acc_now),
    .kind_i    (kind),
    .payload_i (req_payload_i),
    .lreq_o    (lreq_o),
    .busy_o    (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      accept_q <= acc_now;
      reject_q <= rej_now;
    end
  end

  assign busy_o   = busy;
  assign accept_o = accept_q;
  assign reject_o = reject_q;
endmodule

// File: rtl/lreq_issue_ctrl_chk.sv
module lreq_issue_ctrl_chk
  import lreq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [6:0] req_stb_i,
  input logic [1:0] ctl_state_i,
  input logic       link_owns_ctl_i,
  input logic       iso_hold_i,
  input logic       bus_reset_i,
  input logic       lreq_o,
  input logic       busy_o,
  input logic       accept_o,
  input logic       reject_o,
  input logic       bus_pend_i,
  input logic       rd_pend_i
);
  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !lreq_o);

  a_r1_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (lreq_o && busy_o));

  a_r2_one_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> !$past(busy_o));

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && reject_o));

  a_r4_no_second_arb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(|req_stb_i[3:0])) |-> !$past(bus_pend_i));

  a_r6_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_reset_i) |-> !bus_pend_i);

  a_r7_read_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(req_stb_i[K_RDREG] || req_stb_i[K_WRREG])) |-> !$past(rd_pend_i));

  a_r8_fair_pri_ctl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(req_stb_i[K_FAIR] || req_stb_i[K_PRI]))
      |-> $past(!link_owns_ctl_i && !ctl_state_i[1]));

  a_r10_no_iso_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(req_stb_i[K_ISO])) |-> !$past(iso_hold_i));
endmodule

bind lreq_issue_ctrl lreq_issue_ctrl_chk i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_stb_i       (req_stb_i),
  .ctl_state_i     (ctl_state_i),
  .link_owns_ctl_i (link_owns_ctl_i),
  .iso_hold_i      (iso_hold_i),
  .bus_reset_i     (bus_reset_i),
  .lreq_o          (lreq_o),
  .busy_o          (busy_o),
  .accept_o        (accept_o),
  .reject_o        (reject_o),
  .bus_pend_i      (bus_pend),
  .rd_pend_i       (rd_pend)
);

// File: tb/test_lreq_issue_ctrl.sv
`timescale 1ns/1ps
module test_lreq_issue_ctrl;
  localparam int FRAME_W = 9;

  typedef struct packed {
    logic [1:0] ctl;
    logic       own;
    logic [2:0] kind;
    logic [3:0] pl;
    logic       pe, hold, ist, iend, aen, cm, exp;
  } vec_t;

  function automatic vec_t mk(logic [1:0] c, logic o, logic [2:0] k, logic p0, logic pe,
                              logic hold, logic ist, logic iend, logic aen, logic cm, logic e);
    return '{ctl: c, own: o, kind: k, pl: {3'b101, p0}, pe: pe, hold: hold,
             ist: ist, iend: iend, aen: aen, cm: cm, exp: e};
  endfunction

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    mk(2'b00,0,3,0, 0,0,0,0,0,0, 1), mk(2'b01,0,3,0, 0,0,0,0,0,0, 1),
    mk(2'b10,0,3,0, 0,0,0,0,0,0, 0), mk(2'b11,0,2,0, 0,0,0,0,0,0, 0),
    mk(2'b00,1,2,0, 0,0,0,0,0,0, 0), mk(2'b01,0,2,0, 0,0,0,0,0,0, 1),
    mk(2'b10,0,0,0, 1,0,0,0,0,0, 1), mk(2'b00,0,0,0, 1,0,0,0,0,0, 1),
    mk(2'b01,0,0,0, 1,0,0,0,0,0, 0), mk(2'b10,1,0,0, 1,0,0,0,0,0, 0),
    mk(2'b10,0,0,0, 0,0,0,0,0,0, 0), mk(2'b11,1,1,0, 0,0,0,0,0,0, 1),
    mk(2'b10,0,1,0, 0,1,0,0,0,0, 0), mk(2'b11,1,4,0, 0,0,0,0,0,0, 1),
    mk(2'b10,1,5,0, 0,0,0,0,0,0, 1), mk(2'b11,1,6,0, 0,0,1,0,1,0, 1),
    mk(2'b00,0,6,0, 0,0,1,0,1,1, 0), mk(2'b00,0,6,0, 0,0,1,0,0,0, 0),
    mk(2'b11,1,6,1, 0,0,0,1,0,0, 1), mk(2'b00,0,6,1, 0,0,0,1,0,1, 0),
    mk(2'b00,0,6,1, 0,0,1,0,1,0, 0)
  };

  logic clk = 0, rst_n = 0;
  logic [6:0] req_stb = '0;
  logic [3:0] payload = '0;
  logic iso_hold = 0, own = 0, pkt_end = 0, iso_start = 0, iso_end = 0;
  logic aen = 0, cm = 0, grant = 0, cancel = 0, gap = 0, bus_reset = 0, rd_done = 0;
  logic [1:0] ctl = 2'b00;
  logic lreq_o, busy_o, accept_o, reject_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lreq_issue_ctrl i_lreq_issue_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_stb_i(req_stb), .req_payload_i(payload),
    .iso_hold_i(iso_hold), .ctl_state_i(ctl), .link_owns_ctl_i(own),
    .pkt_end_i(pkt_end), .iso_start_i(iso_start), .iso_end_i(iso_end),
    .accel_en_i(aen), .cycle_master_i(cm), .grant_i(grant), .cancel_i(cancel),
    .subact_gap_i(gap), .bus_reset_i(bus_reset), .rd_stat_done_i(rd_done),
    .lreq_o(lreq_o), .busy_o(busy_o), .accept_o(accept_o), .reject_o(reject_o));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe one kind for one edge; returns at the negedge where the verdict is visible
  task automatic fire(int k, logic [3:0] pl);
    req_stb = '0; req_stb[k] = 1'b1; payload = pl;
    @(negedge clk);
    req_stb = '0; iso_hold = 0; iso_start = 0; iso_end = 0;
  endtask

  task automatic pulse_pkt_end();
    pkt_end = 1; @(negedge clk); pkt_end = 0;
  endtask

  task automatic clear_pend();
    grant = 1; rd_done = 1; @(negedge clk); grant = 0; rd_done = 0;
  endtask

  function automatic string tag_of(logic [2:0] k);
    case (k)
      3'd2, 3'd3: return "R8";
      3'd0:       return "R9";
      3'd6:       return "R11";
      default:    return "R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [FRAME_W-1:0] exp_frame;
    idle(2);
    chk("R1 reset lreq", lreq_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R3 reset accept", accept_o, 0);
    chk("R3 reset reject", reject_o, 0);
    rst_n = 1;
    idle(2);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      ctl = v.ctl; own = v.own;
      if (v.pe) pulse_pkt_end();
      iso_hold = v.hold; iso_start = v.ist; iso_end = v.iend; aen = v.aen; cm = v.cm;
      fire(int'(v.kind), v.pl);
      chk({tag_of(v.kind), " accept"}, accept_o, v.exp);
      chk({tag_of(v.kind), " reject"}, reject_o, !v.exp);
      chk({tag_of(v.kind), " R3 start"}, lreq_o, v.exp);
      idle(FRAME_W + 1);
      clear_pend();
      aen = 0; cm = 0;
    end
    ctl = 2'b00; own = 0;

    // R1 frame bits: fair, payload 1010
    exp_frame = {1'b1, 3'd3, 4'b1010, 1'b0};
    fire(3, 4'b1010);
    chk("R1 accept", accept_o, 1);
    for (int b = 0; b < FRAME_W; b++) begin
      chk("R1 bit", lreq_o, exp_frame[FRAME_W-1-b]);
      chk("R1 busy", busy_o, 1);
      @(negedge clk);
    end
    chk("R1 busy end", busy_o, 0);
    chk("R1 line idle", lreq_o, 0);
    clear_pend();

    // R2 strobe while frame in flight
    fire(1, 4'h0);
    chk("R2 first accept", accept_o, 1);
    fire(4, 4'h0);
    chk("R2 busy reject", reject_o, 1);
    idle(FRAME_W + 1); clear_pend();

    // R4 outstanding arbitration, cleared by cancel
    fire(3, 4'h1); idle(FRAME_W + 1);
    fire(2, 4'h1);
    chk("R4 pending reject", reject_o, 1);
    cancel = 1; @(negedge clk); cancel = 0;
    fire(2, 4'h1);
    chk("R4 after cancel", accept_o, 1);
    idle(FRAME_W + 1); clear_pend();

    // R5 gap: no effect on fair, clears iso
    fire(3, 4'h2); idle(FRAME_W + 1);
    gap = 1; @(negedge clk); gap = 0;
    fire(3, 4'h2);
    chk("R5 fair kept", reject_o, 1);
    clear_pend();
    fire(1, 4'h2); idle(FRAME_W + 1);
    gap = 1; @(negedge clk); gap = 0;
    fire(1, 4'h2);
    chk("R5 iso cleared", accept_o, 1);
    idle(FRAME_W + 1); clear_pend();

    // R6 bus reset
    fire(2, 4'h3); idle(FRAME_W + 1);
    bus_reset = 1; @(negedge clk); bus_reset = 0;
    fire(2, 4'h3);
    chk("R6 cleared", accept_o, 1);
    idle(FRAME_W + 1); clear_pend();
    bus_reset = 1;
    fire(3, 4'h3);
    bus_reset = 0;
    chk("R6 same cycle", reject_o, 1);
    chk("R6 no frame", busy_o, 0);

    // R7 register read pending
    fire(4, 4'h4); idle(FRAME_W + 1);
    fire(5, 4'h4);
    chk("R7 write blocked", reject_o, 1);
    fire(4, 4'h4);
    chk("R7 read blocked", reject_o, 1);
    rd_done = 1; @(negedge clk); rd_done = 0;
    fire(5, 4'h4);
    chk("R7 after status", accept_o, 1);
    idle(FRAME_W + 1);

    // R9 window edges: 4th cycle ok, 5th late
    pulse_pkt_end(); idle(3);
    fire(0, 4'h5);
    chk("R9 fourth cycle", accept_o, 1);
    idle(FRAME_W + 1); clear_pend();
    pulse_pkt_end(); idle(4);
    fire(0, 4'h5);
    chk("R9 fifth cycle", reject_o, 1);
    chk("R9 no frame", lreq_o, 0);

    // R3 two strobes at once
    req_stb = 7'b0001100; @(negedge clk); req_stb = '0;
    chk("R3 multi reject", reject_o, 1);
    chk("R3 multi accept", accept_o, 0);
    @(negedge clk);
    chk("R3 multi no frame", lreq_o, 0);
    chk("R3 pulse width", reject_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule